// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Supervisor

This block sits between a bridge driver's protection inputs and its gate stages. A digitized overcurrent comparator, an undervoltage flag for the logic and low-side supply, and one undervoltage flag per high-side supply come in. Out go a global shutdown that forces every gate off, a per-leg high-side inhibit, and a fault indication modelled as an open-drain pin: an active-low level plus an output enable.

An overcurrent event counts only after the trip input has stayed high for a blanking window. It is then held in a latch in which the set input wins. The latch releases in one of two ways. In delayed mode it releases on its own once the trip input has stayed low for a programmable number of cycles. In latched mode it waits for a user clear. The user clear also works in delayed mode. Undervoltage conditions are never stored, so their effects follow the flags directly.

All interfaces are plain control and status levels. No data stream passes through the block, so no valid/ready handshake and no back-pressure rules apply. Inputs are assumed to be synchronous to `clk`.

Top module: `fsv_fault_supervisor`

## Requirements
- R1: An overcurrent trip is accepted only at the BLANK_CYC-th consecutive rising edge at which `oc_trip_i` is sampled high. A shorter pulse leaves every output unchanged.
- R2: From the accepting edge onward, `shutdown_o` is 1 and every bit of `hs_inhibit_o` is 1.
- R3: While a fault is active, `fault_oe_o` is 1 and `fault_n_o` is 0. Otherwise `fault_oe_o` is 0 and `fault_n_o` is 1 (released). A fault is active when the overcurrent latch is set or `uv_logic_i` is 1. The overcurrent fault appears after the same edge as R2.
- R4: The latch is set-dominant. While `oc_trip_i` is high, neither `user_clr_i` nor the delay timer can clear the latch.
- R5: `uv_logic_i`=1 asserts `shutdown_o`, all `hs_inhibit_o` bits and the fault indication in the same cycle, with no clock edge in between. The condition is not stored: with the latch clear, every output releases in the cycle the flag falls.
- R6: In delayed mode (`latch_mode_i`=0), a set latch clears at the CLEAR_CYC-th consecutive edge at which `oc_trip_i` is low. Outputs release after that edge and not before it.
- R7: If the trip reasserts before the delay expires, the delay count restarts. This holds even for a single-cycle trip too short to be accepted.
- R8: In latched mode (`latch_mode_i`=1), the latch holds for any length of time. It clears at the first edge at which `user_clr_i` is 1 and `oc_trip_i` is 0.
- R9: In delayed mode, `user_clr_i`=1 with `oc_trip_i`=0 clears the latch at that edge, before the delay expires.
- R10: `uv_high_i[i]`=1 sets only `hs_inhibit_o[i]`. It asserts neither `shutdown_o` nor the fault indication, and it leaves the other legs alone.
- R11: After reset with all inputs low, the latch is clear, `shutdown_o`=0, `hs_inhibit_o`=0, `fault_oe_o`=0 and `fault_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip_i | input | 1 | Digitized overcurrent comparator output, high = over limit |
| uv_logic_i | input | 1 | Logic/low-side supply undervoltage flag, high = under voltage |
| uv_high_i | input | NUM_LEGS | Per-leg high-side supply undervoltage flags |
| latch_mode_i | input | 1 | 0 = delayed self-clear, 1 = hold until user clear |
| user_clr_i | input | 1 | User request to clear the overcurrent fault |
| shutdown_o | output | 1 | Global gate shutdown, high = all gates off |
| hs_inhibit_o | output | NUM_LEGS | Per-leg high-side gate inhibit |
| fault_n_o | output | 1 | Fault pin level, low while a fault is active |
| fault_oe_o | output | 1 | Fault pin drive enable (pull-down active) |

## Verification
The undervoltage results are combinational, so they are due in the same cycle as the flag. They are sampled one nanosecond after the input is driven. Overcurrent acceptance is due right after the BLANK_CYC-th high edge, and release right after the CLEAR_CYC-th low edge or after the clearing edge. The directed checks therefore sample at falling edges, one cycle before and one cycle after each expected transition. A behavioural reference model counts trip run lengths with integers and updates at every rising edge. All outputs are compared against it one nanosecond later, while the inputs are still stable.

// File: rtl/fsv_pkg.sv
package fsv_pkg;

  typedef enum logic {
    CLR_DELAYED = 1'b0,
    CLR_LATCHED = 1'b1
  } clr_mode_e;

  function automatic int cnt_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

endpackage

// File: rtl/fsv_blanker.sv
module fsv_blanker #(
  parameter int BLANK_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic accept_o
);
  localparam int BW = fsv_pkg::cnt_width(BLANK_CYC);
  localparam logic [BW-1:0] LAST = BW'(BLANK_CYC - 1);

  logic [BW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= '0;
    else if (!trip_i)     run_q <= '0;
    else if (run_q != LAST) run_q <= run_q + 1'b1;
  end

  assign accept_o = trip_i && (run_q == LAST);

  generate
    if (BLANK_CYC >= 2) begin : g_hist_chk
      // R1: acceptance needs the trip seen at the previous edge as well
      a_r1_blank_history: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(trip_i));
    end
  endgenerate
endmodule

// File: rtl/fsv_clear_timer.sv
module fsv_clear_timer #(
  parameter int CLEAR_CYC = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int CW = fsv_pkg::cnt_width(CLEAR_CYC);
  localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  generate
    if (CLEAR_CYC >= 2) begin : g_restart_chk
      // R7: an interruption of the low run forbids expiry on the next cycle
      a_r7_restart_delay: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !expire_o);
    end
  endgenerate
endmodule

// File: rtl/fsv_oc_latch.sv
module fsv_oc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic trip_i,
  input  logic clr_user_i,
  input  logic clr_timer_i,
  output logic q_o
);
  logic clr_ok;

  assign clr_ok = !trip_i && (clr_user_i || clr_timer_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_ok) q_o <= 1'b0;
  end

  // R4: an active trip keeps a set latch set
  a_r4_set_dominant: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && trip_i) |=> q_o);
endmodule

// File: rtl/fsv_fault_supervisor.sv
module fsv_fault_supervisor #(
  parameter int NUM_LEGS  = 3,
  parameter int BLANK_CYC = 25,
  parameter int CLEAR_CYC = 300000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                oc_trip_i,
  input  logic                uv_logic_i,
  input  logic [NUM_LEGS-1:0] uv_high_i,
  input  logic                latch_mode_i,
  input  logic                user_clr_i,
  output logic                shutdown_o,
  output logic [NUM_LEGS-1:0] hs_inhibit_o,
  output logic                fault_n_o,
  output logic                fault_oe_o
);
  import fsv_pkg::*;

  clr_mode_e mode;
  logic      accept;
  logic      oc_latched;
  logic      timer_run;
  logic      timer_expire;
  logic      fault_any;

  assign mode = clr_mode_e'(latch_mode_i);

  fsv_blanker #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_i  (oc_trip_i),
    .accept_o(accept)
  );

  assign timer_run = oc_latched && !oc_trip_i && (mode == CLR_DELAYED);

  fsv_clear_timer #(.CLEAR_CYC(CLEAR_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (timer_run),
    .expire_o(timer_expire)
  );

  fsv_oc_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (accept),
    .trip_i     (oc_trip_i),
    .clr_user_i (user_clr_i),
    .clr_timer_i(timer_expire),
    .q_o        (oc_latched)
  );

  assign fault_any  = oc_latched || uv_logic_i;
  assign shutdown_o = fault_any;
  assign fault_oe_o = fault_any;
  assign fault_n_o  = !fault_any;

  generate
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      assign hs_inhibit_o[g] = shutdown_o || uv_high_i[g];

      // R10: a high-side undervoltage blocks its own leg
      a_r10_leg_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        uv_high_i[g] |-> hs_inhibit_o[g]);
    end
  endgenerate

  // R2: an accepted trip forces shutdown from the next cycle
  a_r2_accept_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (shutdown_o && (&hs_inhibit_o)));

  // R3: a held overcurrent fault drives the fault pin low
  a_r3_fault_pin: assert property (@(posedge clk) disable iff (!rst_n)
    oc_latched |-> (fault_oe_o && !fault_n_o));

  // R5: logic-supply undervoltage acts without a clock edge
  a_r5_uv_logic: assert property (@(posedge clk) disable iff (!rst_n)
    uv_logic_i |-> (shutdown_o && fault_oe_o && !fault_n_o));

  // R6: before expiry, with no user clear, the fault is kept
  a_r6_hold_until_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latched && !user_clr_i && !timer_expire) |=> oc_latched);

  // R8: latched mode ignores everything but the user clear
  a_r8_latched_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_latched && latch_mode_i && !user_clr_i) |=> oc_latched);
endmodule

// File: tb/fsv_fault_supervisor_bench.sv
module fsv_fault_supervisor_bench;
  localparam int LEGS  = 3;
  localparam int BLANK = 25;
  localparam int CLR   = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            oc_trip = 1'b0;
  logic            uv_logic = 1'b0;
  logic [LEGS-1:0] uv_high = '0;
  logic            lmode = 1'b0;
  logic            uclr = 1'b0;
  logic            shutdown;
  logic [LEGS-1:0] hs_inh;
  logic            fault_n;
  logic            fault_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  fsv_fault_supervisor #(.NUM_LEGS(LEGS), .BLANK_CYC(BLANK), .CLEAR_CYC(CLR)) u_fsv_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .oc_trip_i(oc_trip), .uv_logic_i(uv_logic),
    .uv_high_i(uv_high), .latch_mode_i(lmode), .user_clr_i(uclr),
    .shutdown_o(shutdown), .hs_inhibit_o(hs_inh), .fault_n_o(fault_n), .fault_oe_o(fault_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_high_run = 0;
  int m_low_run  = 0;
  bit m_latch    = 1'b0;

  always @(posedge clk) begin
    bit nxt;
    if (!rst_n) begin
      m_high_run = 0; m_low_run = 0; m_latch = 1'b0;
    end else begin
      m_high_run = oc_trip ? m_high_run + 1 : 0;
      nxt = m_latch;
      if (m_latch && !oc_trip && !lmode) m_low_run = m_low_run + 1;
      else m_low_run = 0;
      if (oc_trip && m_high_run >= BLANK) nxt = 1'b1;
      else if (m_latch && !oc_trip && (uclr || (!lmode && m_low_run == CLR))) nxt = 1'b0;
      m_latch = nxt;
    end
    #1;
    if (rst_n && !done) begin
      bit es;
      es = m_latch || uv_logic;
      chk(shutdown == es, "R2 model shutdown", shutdown, es);
      chk(fault_oe == es && fault_n == !es, "R3 model fault pin", {fault_oe, fault_n}, {es, !es});
      chk(hs_inh == ({LEGS{es}} | uv_high), "R10 model hs_inhibit", hs_inh, {LEGS{es}} | uv_high);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_oc(input bit exp, input string tag);
    chk(shutdown == exp && fault_oe == exp && fault_n == !exp, tag, shutdown, exp);
  endtask

  task automatic trip_latch();
    oc_trip = 1'b1;
    cyc(BLANK);
    oc_trip = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R11 reset state
    chk(shutdown == 0 && hs_inh == 0 && fault_oe == 0 && fault_n == 1, "R11 reset state", {shutdown, fault_oe, fault_n}, 3'b001);

    // R1 a pulse one cycle short of the blanking window is ignored
    oc_trip = 1'b1;
    cyc(BLANK - 1);
    oc_trip = 1'b0;
    cyc(1);
    chk_oc(1'b0, "R1 short pulse ignored");
    cyc(3);

    // R1/R2/R3 exact acceptance edge
    oc_trip = 1'b1;
    cyc(BLANK - 1);
    chk_oc(1'b0, "R1 not yet accepted");
    cyc(1);
    chk_oc(1'b1, "R2 accepted shutdown");
    chk(hs_inh == '1, "R2 all high sides off", hs_inh, 7);
    chk(fault_oe == 1 && fault_n == 0, "R3 fault pin driven low", fault_n, 0);

    // R4 clear attempts while trip is high
    uclr = 1'b1;
    cyc(4);
    uclr = 1'b0;
    chk_oc(1'b1, "R4 clear blocked by active trip");

    // R6 delayed self-clear
    oc_trip = 1'b0;
    cyc(CLR - 1);
    chk_oc(1'b1, "R6 still held before expiry");
    cyc(1);
    chk_oc(1'b0, "R6 released at expiry");

    // R7 restart on a one-cycle re-trip
    trip_latch();
    cyc(10);
    oc_trip = 1'b1;
    cyc(1);
    oc_trip = 1'b0;
    cyc(CLR - 1);
    chk_oc(1'b1, "R7 count restarted after re-trip");
    cyc(1);
    chk_oc(1'b0, "R7 released after full restarted delay");

    // R8 latched mode
    lmode = 1'b1;
    trip_latch();
    cyc(3 * CLR);
    chk_oc(1'b1, "R8 latched mode holds");
    uclr = 1'b1;
    cyc(1);
    uclr = 1'b0;
    chk_oc(1'b0, "R8 user clear releases");
    lmode = 1'b0;
    cyc(2);

    // R9 user clear in delayed mode before expiry
    trip_latch();
    cyc(5);
    chk_oc(1'b1, "R9 held before user clear");
    uclr = 1'b1;
    cyc(1);
    uclr = 1'b0;
    chk_oc(1'b0, "R9 user clear in delayed mode");
    cyc(2);

    // R5 logic undervoltage, combinational and unlatched
    uv_logic = 1'b1;
    #1;
    chk(shutdown == 1 && hs_inh == '1 && fault_oe == 1 && fault_n == 0, "R5 uv asserts at once", {shutdown, fault_oe, fault_n}, 3'b110);
    cyc(4);
    uv_logic = 1'b0;
    #1;
    chk(shutdown == 0 && hs_inh == 0 && fault_oe == 0 && fault_n == 1, "R5 uv releases at once", {shutdown, fault_oe, fault_n}, 3'b001);
    cyc(2);

    // R10 single-leg high-side undervoltage
    uv_high = 3'b010;
    #1;
    chk(hs_inh == 3'b010, "R10 only leg 1 inhibited", hs_inh, 2);
    chk(shutdown == 0 && fault_oe == 0 && fault_n == 1, "R10 no shutdown or fault", {shutdown, fault_oe}, 0);
    cyc(3);
    uv_high = '0;
    cyc(3);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule